// File: doc/BRIEF.md
# Even/Odd Split 2-D Wavelet Analysis Filter

This block computes one level of a two-dimensional wavelet analysis with a non-separable 4×4 kernel built from fixed four-tap Daubechies coefficients. Each accepted clock brings two horizontally adjacent pixels of the current row. The even-column pixel arrives on `px_even` and the odd-column pixel on `px_odd`. The same two columns of the three rows above arrive on the `abN_*` inputs. Internal column history completes the 4×4 window. The four kernel taps on even window columns are summed in an even path, and the taps on odd window columns in an odd path. The two partial results are added, rounded and clamped to 14 bits.

Decimation by two is applied in both directions. Each pixel pair of an even row gives one output position, and pairs of odd rows only update the column history. A local sequencer holds each group of four subband results. It steps through the states ST_IDLE, ST_LL, ST_LH, ST_HL and ST_HH and places one result per cycle on a single tagged output. The transitions are:
- ST_IDLE moves to ST_LL when a group is ready and otherwise stays.
- ST_LL moves to ST_LH, ST_LH moves to ST_HL, and ST_HL moves to ST_HH, each unconditionally.
- ST_HH moves to ST_LL when another group is ready and otherwise returns to ST_IDLE.

Pairs on output rows must be spaced at least four cycles apart. Pairs on odd rows may arrive every cycle.

Top module: `dwt_eo_filter`

## Requirements
- R1: After reset, `out_valid` is 0, `out_band` is 00 and `out_coef` is 0 until the first group is emitted.
- R2: The LL result of an accepted even-row pair appears with `out_valid` high exactly 8 clock cycles after the clock edge that accepted the pair.
- R3: Each group is emitted on 4 consecutive valid cycles with tags 00 (LL), 01 (LH), 10 (HL), 11 (HH), in that order.
- R4: For output position c of even row r, a tag with row filter f1 and column filter f2 carries round(sum over k1,k2 in 0..3 of f1(k1)·f2(k2)·S(r−k1, 2c−k2) / 65536), where the rounding adds 32768 and then floor-shifts by 16. The result is clamped to the range −8192..8191. The lowpass taps are g = (124, 214, 57, −33), which is the Daubechies-4 set scaled by 256 and held as 9-bit signed values.
- R5: The highpass taps are h(k) = (−1)^k·g(3−k), giving (−33, −57, 214, −124). Tag bit 1 selects h for the rows (k1) and tag bit 0 selects h for the columns (k2).
- R6: Pixel column 2c comes from `px_even` and column 2c+1 from `px_odd` of the c-th pair in a row. The odd pixel of a pair does not enter that pair's own result, and first contributes to position c+1.
- R7: Columns to the left of the first pair of a line (`line_start` or `frame_start` high) are treated as zero.
- R8: Rows r−1, r−2 and r−3 are taken from `ab1_*`, `ab2_*` and `ab3_*`. Zero rows above the image are supplied by the caller.
- R9: The row with `frame_start` is even, and row parity toggles on every `line_start`. Pairs of odd rows produce no output.
- R10: Even-row pairs spaced exactly 4 cycles apart give an unbroken stream of valid outputs, one group every 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A pixel pair is presented this cycle |
| frame_start | input | 1 | First pair of a frame (also starts a line, row even) |
| line_start | input | 1 | First pair of a line |
| px_even | input | 8 | Current row, even column pixel |
| px_odd | input | 8 | Current row, odd column pixel |
| ab1_even | input | 8 | Row above, even column |
| ab1_odd | input | 8 | Row above, odd column |
| ab2_even | input | 8 | Two rows above, even column |
| ab2_odd | input | 8 | Two rows above, odd column |
| ab3_even | input | 8 | Three rows above, even column |
| ab3_odd | input | 8 | Three rows above, odd column |
| out_valid | output | 1 | Output coefficient valid |
| out_band | output | 2 | Subband tag |
| out_coef | output | 14 | Signed subband coefficient |

## Verification
On every cycle the assertions check the tag order inside a group, that a group opens with LL, that no group arrives while the sequencer is mid-group, that the history columns are zero after a line start, and that a frame-start pair is treated as an even row. The bench scenarios are the only check of the arithmetic values, the 8-cycle latency, the even/odd column mapping, silence on odd rows and unbroken back-to-back streaming. These scenarios use impulse, saturated-white and random frames with both tight and loose pair spacing.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

    localparam int PIX_W   = 8;
    localparam int OUT_W   = 14;
    localparam int ACC_W   = 32;
    localparam int FRAC_W  = 16;
    localparam int NBANDS  = 4;
    localparam int TAPS    = 4;

    typedef logic [TAPS-1:0][PIX_W-1:0]        pcol_t;   // one column, index = k1
    typedef logic [TAPS-1:0][TAPS-1:0][PIX_W-1:0] win_t; // [k1][k2]
    typedef logic signed [ACC_W-1:0]           acc_t;
    typedef logic [NBANDS-1:0][ACC_W-1:0]      bacc_t;
    typedef logic [NBANDS-1:0][OUT_W-1:0]      bres_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LL,
        ST_LH,
        ST_HL,
        ST_HH
    } seq_st_t;

    // Quantized lowpass taps, scale 2^8, 9-bit signed range.
    function automatic int lo_tap(input int k);
        case (k)
            0:       return 124;
            1:       return 214;
            2:       return 57;
            default: return -33;
        endcase
    endfunction

    function automatic int hi_tap(input int k);
        return ((k % 2) == 0) ? lo_tap(3 - k) : -lo_tap(3 - k);
    endfunction

    // band bit1: highpass along rows, band bit0: highpass along columns
    function automatic int kern(input int band, input int k1, input int k2);
        int fr;
        int fc;
        fr = ((band / 2) % 2 == 1) ? hi_tap(k1) : lo_tap(k1);
        fc = (band % 2 == 1) ? hi_tap(k2) : lo_tap(k2);
        return fr * fc;
    endfunction

endpackage

// File: rtl/dwt_col_window.sv
module dwt_col_window
    import dwt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  logic  frame_start,
    input  logic  line_start,
    input  pcol_t col_even,
    input  pcol_t col_odd,
    output logic  win_valid,
    output win_t  win
);

    pcol_t prev_even_q, prev_odd_q, prev2_odd_q;
    pcol_t use_even, use_odd, use_odd2;
    logic  row_odd_q, cur_odd, fresh;
    win_t  win_d;

    always_comb begin
        fresh    = frame_start | line_start;
        cur_odd  = frame_start ? 1'b0 : (line_start ? ~row_odd_q : row_odd_q);
        use_even = fresh ? '0 : prev_even_q;
        use_odd  = fresh ? '0 : prev_odd_q;
        use_odd2 = fresh ? '0 : prev2_odd_q;
        for (int k1 = 0; k1 < TAPS; k1++) begin
            win_d[k1][0] = col_even[k1];
            win_d[k1][1] = use_odd[k1];
            win_d[k1][2] = use_even[k1];
            win_d[k1][3] = use_odd2[k1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_even_q <= '0;
            prev_odd_q  <= '0;
            prev2_odd_q <= '0;
            row_odd_q   <= 1'b0;
            win_valid   <= 1'b0;
            win         <= '0;
        end else begin
            win_valid <= in_valid & ~cur_odd;
            if (in_valid) begin
                prev_even_q <= col_even;
                prev_odd_q  <= col_odd;
                prev2_odd_q <= use_odd;
                row_odd_q   <= cur_odd;
                win         <= win_d;
            end
        end
    end

    // R7: history columns are zero for the first pair of a line
    a_r7_left_edge_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (line_start || frame_start)) |=>
            (win[0][3:1] == '0 && win[1][3:1] == '0 &&
             win[2][3:1] == '0 && win[3][3:1] == '0));

    // R9: the frame-start pair is on an even row and yields a window
    a_r9_frame_row_even: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frame_start) |=> win_valid);

endmodule

// File: rtl/dwt_tap_path.sv
module dwt_tap_path
    import dwt_pkg::*;
#(
    parameter int PARITY = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  win_t  win,
    output bacc_t part
);

    localparam int HALF = TAPS / 2;

    bacc_t part_d;

    always_comb begin
        for (int b = 0; b < NBANDS; b++) begin
            acc_t sum;
            sum = '0;
            for (int k1 = 0; k1 < TAPS; k1++) begin
                for (int j = 0; j < HALF; j++) begin
                    sum = sum + acc_t'(kern(b, k1, PARITY + 2 * j))
                              * acc_t'({1'b0, win[k1][PARITY + 2 * j]});
                end
            end
            part_d[b] = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part <= '0;
        end else if (en) begin
            part <= part_d;
        end
    end

endmodule

// File: rtl/dwt_band_seq.sv
module dwt_band_seq
    import dwt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_valid,
    input  bres_t            grp,
    output logic             out_valid,
    output logic [1:0]       out_band,
    output logic [OUT_W-1:0] out_coef
);

    seq_st_t state_q, state_d;
    bres_t   hold_q;
    logic    can_take;

    assign can_take = (state_q == ST_IDLE) || (state_q == ST_HH);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = grp_valid ? ST_LL : ST_IDLE;
            ST_LL:   state_d = ST_LH;
            ST_LH:   state_d = ST_HL;
            ST_HL:   state_d = ST_HH;
            ST_HH:   state_d = grp_valid ? ST_LL : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (grp_valid && can_take) begin
                hold_q <= grp;
            end
        end
    end

    always_comb begin
        out_valid = 1'b1;
        out_band  = 2'b00;
        out_coef  = '0;
        unique case (state_q)
            ST_IDLE: begin
                out_valid = 1'b0;
            end
            ST_LL: begin
                out_band = 2'b00;
                out_coef = hold_q[0];
            end
            ST_LH: begin
                out_band = 2'b01;
                out_coef = hold_q[1];
            end
            ST_HL: begin
                out_band = 2'b10;
                out_coef = hold_q[2];
            end
            ST_HH: begin
                out_band = 2'b11;
                out_coef = hold_q[3];
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    // R3: tags advance by one inside a group
    a_r3_band_order: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_band != 2'b11) |=>
            (out_valid && out_band == $past(out_band) + 2'd1));

    // R3: a burst of valid outputs opens with LL
    a_r3_ll_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_band == 2'b00));

    // R10: groups never arrive while a group is mid-emission
    a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> can_take);

endmodule

// File: rtl/dwt_eo_filter.sv
module dwt_eo_filter
    import dwt_pkg::*;
#(
    parameter int LATENCY = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             frame_start,
    input  logic             line_start,
    input  logic [7:0]       px_even,
    input  logic [7:0]       px_odd,
    input  logic [7:0]       ab1_even,
    input  logic [7:0]       ab1_odd,
    input  logic [7:0]       ab2_even,
    input  logic [7:0]       ab2_odd,
    input  logic [7:0]       ab3_even,
    input  logic [7:0]       ab3_odd,
    output logic             out_valid,
    output logic [1:0]       out_band,
    output logic [13:0]      out_coef
);

    localparam int   PAD  = LATENCY - 3;
    localparam acc_t RND  = acc_t'(1) <<< (FRAC_W - 1);
    localparam acc_t MAXV = acc_t'((1 << (OUT_W - 1)) - 1);
    localparam acc_t MINV = -acc_t'(1 << (OUT_W - 1));

    pcol_t col_even, col_odd;
    win_t  win;
    logic  win_valid, part_valid, res_valid;
    bacc_t part_e, part_o;
    bres_t res_d, res_q;
    logic  grp_valid;
    bres_t grp;

    assign col_even = {ab3_even, ab2_even, ab1_even, px_even};
    assign col_odd  = {ab3_odd,  ab2_odd,  ab1_odd,  px_odd};

    dwt_col_window u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .frame_start (frame_start),
        .line_start  (line_start),
        .col_even    (col_even),
        .col_odd     (col_odd),
        .win_valid   (win_valid),
        .win         (win)
    );

    dwt_tap_path #(.PARITY(0)) u_even_path (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (win_valid),
        .win   (win),
        .part  (part_e)
    );

    dwt_tap_path #(.PARITY(1)) u_odd_path (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (win_valid),
        .win   (win),
        .part  (part_o)
    );

    always_comb begin
        for (int b = 0; b < NBANDS; b++) begin
            acc_t s;
            acc_t r;
            s = $signed(part_e[b]) + $signed(part_o[b]);
            r = (s + RND) >>> FRAC_W;
            if (r > MAXV)      r = MAXV;
            else if (r < MINV) r = MINV;
            res_d[b] = r[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_valid <= 1'b0;
            res_valid  <= 1'b0;
            res_q      <= '0;
        end else begin
            part_valid <= win_valid;
            res_valid  <= part_valid;
            if (part_valid) begin
                res_q <= res_d;
            end
        end
    end

    generate
        if (PAD > 0) begin : g_pad
            logic  [PAD-1:0] v_q;
            bres_t           d_q [PAD];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q <= '0;
                    for (int i = 0; i < PAD; i++) d_q[i] <= '0;
                end else begin
                    v_q[0] <= res_valid;
                    d_q[0] <= res_q;
                    for (int i = 1; i < PAD; i++) begin
                        v_q[i] <= v_q[i-1];
                        d_q[i] <= d_q[i-1];
                    end
                end
            end
            assign grp_valid = v_q[PAD-1];
            assign grp       = d_q[PAD-1];
        end else begin : g_nopad
            assign grp_valid = res_valid;
            assign grp       = res_q;
        end
    endgenerate

    dwt_band_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_valid (grp_valid),
        .grp       (grp),
        .out_valid (out_valid),
        .out_band  (out_band),
        .out_coef  (out_coef)
    );

endmodule

// File: tb/dwt_eo_filter_tb.sv
module dwt_eo_filter_tb_top;

    localparam int NROW = 8;
    localparam int NPAIR = 4;
    localparam int MAXG = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, frame_start = 1'b0, line_start = 1'b0;
    logic [7:0] px_even = '0, px_odd = '0, ab1_even = '0, ab1_odd = '0;
    logic [7:0] ab2_even = '0, ab2_odd = '0, ab3_even = '0, ab3_odd = '0;
    logic out_valid;
    logic [1:0] out_band;
    logic [13:0] out_coef;

    int img [NROW][2*NPAIR];
    int exp_val [MAXG][4];
    int exp_cyc [MAXG];
    int ngrp = 0, nout = 0, cyc = 0;
    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dwt_eo_filter dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .frame_start(frame_start), .line_start(line_start),
        .px_even(px_even), .px_odd(px_odd),
        .ab1_even(ab1_even), .ab1_odd(ab1_odd),
        .ab2_even(ab2_even), .ab2_odd(ab2_odd),
        .ab3_even(ab3_even), .ab3_odd(ab3_odd),
        .out_valid(out_valid), .out_band(out_band), .out_coef(out_coef)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int gtap(int k);
        int t [4] = '{124, 214, 57, -33};
        return t[k];
    endfunction

    function automatic int ftap(int hp, int k);
        if (hp == 0) return gtap(k);
        return (k % 2 == 0) ? gtap(3 - k) : -gtap(3 - k);
    endfunction

    function automatic int px(int r, int col);
        if (r < 0 || col < 0) return 0;
        return img[r][col];
    endfunction

    function automatic int model(int r, int c, int band);
        longint s = 0;
        longint q;
        for (int k1 = 0; k1 < 4; k1++)
            for (int k2 = 0; k2 < 4; k2++)
                s += longint'(ftap(band / 2, k1) * ftap(band % 2, k2)) * px(r - k1, 2 * c - k2);
        q = (s + 32768) >>> 16;
        if (q > 8191) q = 8191;
        if (q < -8192) q = -8192;
        return int'(q);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor: R2 timing, R3 order, R4/R5/R6/R7/R8 values, R9 no extra, R10 stream
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            int g;
            int b;
            g = nout / 4;
            b = nout % 4;
            if (g >= ngrp) begin
                check(0, "R9 unexpected output", nout, 4 * ngrp);
            end else begin
                check(int'(out_band) == b, "R3 band tag", int'(out_band), b);
                check(cyc == exp_cyc[g] + b, "R2/R10 output cycle", cyc, exp_cyc[g] + b);
                check(int'($signed(out_coef)) == exp_val[g][b], "R4/R5 coefficient",
                      int'($signed(out_coef)), exp_val[g][b]);
            end
            nout++;
        end
    end

    task automatic send_pair(int r, int c, bit fs, bit ls);
        @(negedge clk);
        in_valid    = 1'b1;
        frame_start = fs;
        line_start  = ls;
        px_even  = 8'(px(r, 2*c));       px_odd  = 8'(px(r, 2*c+1));
        ab1_even = 8'(px(r-1, 2*c));     ab1_odd = 8'(px(r-1, 2*c+1));
        ab2_even = 8'(px(r-2, 2*c));     ab2_odd = 8'(px(r-2, 2*c+1));
        ab3_even = 8'(px(r-3, 2*c));     ab3_odd = 8'(px(r-3, 2*c+1));
        if (r % 2 == 0) begin
            for (int b = 0; b < 4; b++) exp_val[ngrp][b] = model(r, c, b);
            exp_cyc[ngrp] = cyc + 9;
            ngrp++;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; frame_start = 1'b0; line_start = 1'b0;
            px_odd = 8'($urandom);  // junk while idle must not matter
        end
    endtask

    // mode 0: tight (gap 3 on even rows, 0 on odd), 1: random loose gaps
    task automatic run_frame(int mode);
        for (int r = 0; r < NROW; r++) begin
            for (int c = 0; c < NPAIR; c++) begin
                send_pair(r, c, (r == 0 && c == 0), (c == 0));
                if (r % 2 == 0) idle(mode == 0 ? 3 : 3 + int'($urandom % 4));
                else if (mode != 0) idle(int'($urandom % 3));
            end
        end
        idle(1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(out_band == 2'b00, "R1 out_band after reset", int'(out_band), 0);
        check(out_coef == 14'd0, "R1 out_coef after reset", int'(out_coef), 0);

        // Directed: impulse on an odd column (R6, R7, R8)
        foreach (img[r, c]) img[r][c] = 0;
        img[2][3] = 200;
        run_frame(0);
        // Directed: impulse at column 0 of first row (R7 left edge)
        foreach (img[r, c]) img[r][c] = 0;
        img[0][0] = 255; img[1][1] = 17;
        run_frame(1);
        // Directed: all white, back-to-back (R10)
        foreach (img[r, c]) img[r][c] = 255;
        run_frame(0);
        // Random frames, mixed spacing
        for (int f = 0; f < 6; f++) begin
            foreach (img[r, c]) img[r][c] = int'($urandom % 256);
            run_frame(f % 2);
        end
        idle(20);
        // R9: exactly one group per even-row pair, none for odd rows
        check(nout == 4 * ngrp, "R9 output count", nout, 4 * ngrp);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait (cyc > 100000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule